// File: doc/BRIEF.md
# Byte-Lane Data Memory with Alignment Trap

This block is the data-memory port of a 16-bit datapath whose addresses count bytes. Storage is two parallel 8-bit lanes that share one word-index decoder. Each lane has its own write enable. The lane is picked by address bit 0: even addresses hold the low byte of a word and odd addresses hold the high byte. Byte reads fetch the whole word and return the selected byte on the low half of the read bus. Byte writes touch only the matching lane. Word accesses must use even addresses.

A word access to an odd address is treated as misaligned. A misaligned read still finishes and returns data. A misaligned write changes nothing. In both cases a one-cycle trap request is registered together with the faulting address and the access direction, for the exception logic outside this block. The port also outputs the post-increment pointer value for the current access: the address plus 1 for byte accesses, or plus 2 for word accesses.

Top module: `bytelane_dmem`

## Requirements
- R1: A byte read of address A returns byte A of memory on rd_data[7:0]. Bit 0 of A picks the lane: 0 selects the low lane (word bits 7:0) and 1 selects the high lane (word bits 15:8).
- R2: On every byte read, rd_data[15:8] is zero.
- R3: A byte write stores wdata[7:0] into byte A only, using only the lane chosen by bit 0 of A. The other byte of that word keeps its value.
- R4: A word write to an even address A stores wdata[7:0] at byte A and wdata[15:8] at byte A+1. A word read of an even A returns {byte A+1, byte A}.
- R5: A word access (read or write) to an odd address A raises trap_pulse for exactly one cycle, in the cycle after the request. In that cycle trap_addr equals A and trap_write equals the access direction (1 = write). Aligned accesses and byte accesses never raise trap_pulse.
- R6: A misaligned word read still completes. rd_valid is asserted and rd_data holds {byte A|1, byte A&~1}, the word whose index is A with bit 0 ignored.
- R7: A misaligned word write modifies no byte of memory.
- R8: ptr_next equals req_addr+1 when req_byte=1 and req_addr+2 when req_byte=0. It is combinational and wraps modulo 2^ADDR_W.
- R9: While rst_n is low at a clock edge, rd_valid, trap_pulse and trap_write become 0 and trap_addr becomes 0. The memory contents are not reset.
- R10: Read data and rd_valid appear in the cycle after the read request. A write becomes visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| ptr_next | output | ADDR_W | Post-incremented pointer value |
| rd_valid | output | 1 | Read data valid (one cycle after the read request) |
| rd_data | output | 16 | Read data, already aligned |
| trap_pulse | output | 1 | One-cycle address-error trap request |
| trap_addr | output | ADDR_W | Address of the last misaligned access |
| trap_write | output | 1 | Direction of the last misaligned access |

## Verification
ptr_next is combinational, so it is checked shortly after the inputs are driven and before the clock edge. rd_valid, rd_data, trap_pulse, trap_addr and trap_write are registered at the request edge. Each access task waits for that edge and samples one time unit later, before the next request is driven. A write is checked indirectly: a read issued in the following cycle is compared against the reference byte array. The misaligned cases check the trap outputs one cycle after the request and also confirm, through later reads, that no byte was changed.

// File: rtl/dmem_pkg.sv
// Package: shared types and constants for the byte-lane data memory.
// Assumes a 16-bit word made of two 8-bit lanes.
package dmem_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 2;
    localparam int WORD_W  = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0] byte_t;

    // Access width as encoded on req_byte
    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_BYTE = 1'b1
    } acc_size_e;
endpackage

// File: rtl/dmem_decode.sv
// Module: dmem_decode
// Decodes one request into a word index, per-lane write enables and data,
// a misalignment flag and the post-increment pointer value.
// Assumes: lane 0 = even byte, lane 1 = odd byte; a byte write carries its
// data on wdata[7:0]; a misaligned word write must not enable any lane.
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_byte,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_W-1:0]       req_wdata,
    output logic [IDX_W-1:0]        word_idx,
    output logic                    rd_en,
    output logic                    misaligned,
    output logic [LANES-1:0]        lane_we,
    output byte_t [LANES-1:0]       lane_wdata,
    output logic [ADDR_W-1:0]       ptr_next
);
    acc_size_e size;
    logic      odd;

    // Purpose: classify the request width and alignment
    always_comb begin
        size       = acc_size_e'(req_byte);
        odd        = req_addr[0];
        word_idx   = req_addr[ADDR_W-1:1];
        misaligned = req_valid && (size == ACC_WORD) && odd;
        rd_en      = req_valid && !req_write;
    end

    // Purpose: steer write enables and write data onto the two lanes
    always_comb begin
        lane_we    = '0;
        lane_wdata = '0;
        if (size == ACC_BYTE) begin
            lane_wdata[0] = req_wdata[BYTE_W-1:0];
            lane_wdata[1] = req_wdata[BYTE_W-1:0];
            if (req_valid && req_write) begin
                lane_we[odd] = 1'b1;
            end
        end else begin
            lane_wdata[0] = req_wdata[BYTE_W-1:0];
            lane_wdata[1] = req_wdata[WORD_W-1:BYTE_W];
            if (req_valid && req_write && !odd) begin
                lane_we = '1;
            end
        end
    end

    // Purpose: post-increment step of one byte or one word
    always_comb begin
        if (size == ACC_BYTE) begin
            ptr_next = req_addr + ADDR_W'(1);
        end else begin
            ptr_next = req_addr + ADDR_W'(2);
        end
    end
endmodule

// File: rtl/dmem_lane.sv
// Module: dmem_lane
// One 8-bit wide storage lane with synchronous write and registered read.
// Assumes at most one access (read or write) per cycle; contents are not reset.
module dmem_lane
    import dmem_pkg::*;
#(
    parameter int IDX_W = 7,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  byte_t             wdata,
    output byte_t             rdata
);
    byte_t mem [DEPTH];

    // Purpose: write the lane byte when enabled
    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Purpose: registered read of the addressed byte
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/dmem_rdalign.sv
// Module: dmem_rdalign
// Registers the read-side control and aligns the lane outputs: a byte read
// returns the chosen lane on bits 7:0 with zeros above; a word read (aligned
// or not) returns {lane1, lane0} of the addressed word.
module dmem_rdalign
    import dmem_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               req_byte,
    input  logic               addr_lsb,
    input  byte_t [LANES-1:0]  lane_rdata,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data
);
    logic byte_q;
    logic lsb_q;

    // Purpose: capture read control alongside the lane read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            byte_q   <= 1'b0;
            lsb_q    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                byte_q <= req_byte;
                lsb_q  <= addr_lsb;
            end
        end
    end

    // Purpose: select and place the returned byte or word
    always_comb begin
        if (byte_q) begin
            rd_data = {{BYTE_W{1'b0}}, lane_rdata[lsb_q]};
        end else begin
            rd_data = {lane_rdata[1], lane_rdata[0]};
        end
    end

    // R2: upper half is zero on byte reads
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && req_byte) |=> (rd_data[WORD_W-1:BYTE_W] == '0));

    // R6 / R10: every read, aligned or not, completes one cycle later
    p_read_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R10: no valid without a read the cycle before
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/dmem_trap.sv
// Module: dmem_trap
// Registers a one-cycle address-error request with the faulting address and
// direction. Address and direction hold until the next misaligned access.
module dmem_trap #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              misaligned,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              trap_pulse,
    output logic [ADDR_W-1:0] trap_addr,
    output logic              trap_write
);
    // Purpose: latch the trap request and its context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse <= 1'b0;
            trap_addr  <= '0;
            trap_write <= 1'b0;
        end else begin
            trap_pulse <= misaligned;
            if (misaligned) begin
                trap_addr  <= req_addr;
                trap_write <= req_write;
            end
        end
    end

    // R5: misaligned access traps next cycle with its address and direction
    p_trap_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |=> (trap_pulse && trap_addr == $past(req_addr)
                        && trap_write == $past(req_write)));

    // R5: no trap without a misaligned access
    p_no_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !misaligned |=> !trap_pulse);

    // R5: recorded context holds while no new fault arrives
    p_ctx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!misaligned && $past(rst_n)) |=> $stable(trap_addr));
endmodule

// File: rtl/bytelane_dmem.sv
// Module: bytelane_dmem (top)
// A byte-addressable, 16-bit data memory built from two byte lanes that share
// a word-index decoder. Aligns byte reads, steers byte writes, suppresses
// misaligned word writes, requests an address-error trap and gives the
// post-increment pointer. Assumes one request per cycle.
module bytelane_dmem
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_byte,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic [ADDR_W-1:0]   ptr_next,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic                trap_pulse,
    output logic [ADDR_W-1:0]   trap_addr,
    output logic                trap_write
);
    logic [IDX_W-1:0]   word_idx;
    logic               rd_en;
    logic               misaligned;
    logic [LANES-1:0]   lane_we;
    byte_t [LANES-1:0]  lane_wdata;
    byte_t [LANES-1:0]  lane_rdata;

    dmem_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_byte   (req_byte),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .word_idx   (word_idx),
        .rd_en      (rd_en),
        .misaligned (misaligned),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .ptr_next   (ptr_next)
    );

    // One storage lane per byte of the word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmem_lane #(.IDX_W(IDX_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .re    (rd_en),
            .idx   (word_idx),
            .wdata (lane_wdata[g]),
            .rdata (lane_rdata[g])
        );
    end

    dmem_rdalign u_rdalign (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .req_byte   (req_byte),
        .addr_lsb   (req_addr[0]),
        .lane_rdata (lane_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    dmem_trap #(.ADDR_W(ADDR_W)) u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .misaligned (misaligned),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .trap_pulse (trap_pulse),
        .trap_addr  (trap_addr),
        .trap_write (trap_write)
    );

    // R3: a byte write enables exactly the lane named by address bit 0
    p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_byte)
        |-> ($countones(lane_we) == 1 && lane_we[req_addr[0]]));

    // R7: a misaligned word write enables no lane
    p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_byte && req_addr[0]) |-> (lane_we == '0));

    // R4: an aligned word write enables both lanes
    p_word_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_byte && !req_addr[0]) |-> (&lane_we));
endmodule

// File: tb/bytelane_dmem_tb.sv
module bytelane_dmem_tb;
    localparam int AW    = 8;
    localparam int NBYTE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_byte = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [AW-1:0] ptr_next;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic          trap_pulse;
    logic [AW-1:0] trap_addr;
    logic          trap_write;

    logic [7:0] ref_mem [NBYTE];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bytelane_dmem #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .ptr_next(ptr_next), .rd_valid(rd_valid), .rd_data(rd_data),
        .trap_pulse(trap_pulse), .trap_addr(trap_addr), .trap_write(trap_write)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input bit b);
        if (b) return {8'h00, ref_mem[a]};
        return {ref_mem[a | AW'(1)], ref_mem[a & ~AW'(1)]};
    endfunction

    // One access; checks ptr_next before the edge and registered results after it
    task automatic access(input bit wr, input bit b, input logic [AW-1:0] a,
                          input logic [15:0] wd);
        logic [AW-1:0] step;
        bit mis;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_byte = b; req_addr = a; req_wdata = wd;
        #1;
        step = b ? AW'(1) : AW'(2);
        check(ptr_next == a + step, "R8 ptr_next", 32'(ptr_next), 32'(a + step));
        mis = !b && a[0];
        @(posedge clk);
        #1;
        check(trap_pulse == mis, "R5 trap_pulse", 32'(trap_pulse), 32'(mis));
        if (mis) begin
            check(trap_addr == a, "R5 trap_addr", 32'(trap_addr), 32'(a));
            check(trap_write == wr, "R5 trap_write", 32'(trap_write), 32'(wr));
        end
        if (!wr) begin
            check(rd_valid == 1'b1, "R10/R6 rd_valid", 32'(rd_valid), 32'd1);
            check(rd_data == exp_read(a, b),
                  b ? "R1/R2 byte read" : (mis ? "R6 misaligned read" : "R4 word read"),
                  32'(rd_data), 32'(exp_read(a, b)));
        end else begin
            check(rd_valid == 1'b0, "R10 no rd_valid on write", 32'(rd_valid), 32'd0);
            if (b) ref_mem[a] = wd[7:0];
            else if (!a[0]) begin
                ref_mem[a] = wd[7:0];
                ref_mem[a | AW'(1)] = wd[15:8];
            end
            // misaligned word write: R7, reference untouched
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check(trap_pulse == 1'b0, "R5 no trap when idle", 32'(trap_pulse), 32'd0);
        check(rd_valid == 1'b0, "R10 no rd_valid when idle", 32'(rd_valid), 32'd0);
    endtask

    initial begin : watchdog
        #(5 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [AW-1:0] ra;
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1;
        check(rd_valid == 1'b0, "R9 rd_valid reset", 32'(rd_valid), 32'd0);
        check(trap_pulse == 1'b0, "R9 trap_pulse reset", 32'(trap_pulse), 32'd0);
        check(trap_addr == '0, "R9 trap_addr reset", 32'(trap_addr), 32'd0);
        check(trap_write == 1'b0, "R9 trap_write reset", 32'(trap_write), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill memory with aligned word writes (R4)
        for (int i = 0; i < NBYTE; i += 2) access(1'b1, 1'b0, AW'(i), 16'($urandom));

        // Directed: word read, byte reads on both lanes (R1, R2, R4)
        access(1'b0, 1'b0, 8'h10, 16'h0);
        access(1'b0, 1'b1, 8'h10, 16'h0);
        access(1'b0, 1'b1, 8'h11, 16'h0);
        // R3: byte write high lane, then low lane, read back word
        access(1'b1, 1'b1, 8'h21, 16'hA5C3);
        access(1'b0, 1'b0, 8'h20, 16'h0);
        access(1'b1, 1'b1, 8'h20, 16'h5A3C);
        access(1'b0, 1'b0, 8'h20, 16'h0);
        // R7: misaligned word write leaves both neighbouring words intact
        access(1'b1, 1'b0, 8'h31, 16'hDEAD);
        access(1'b0, 1'b0, 8'h30, 16'h0);
        access(1'b0, 1'b0, 8'h32, 16'h0);
        // R6: misaligned read returns containing word and traps
        access(1'b0, 1'b0, 8'h45, 16'h0);
        // R5: trap context holds after idle
        idle();
        check(trap_addr == 8'h45, "R5 trap_addr held", 32'(trap_addr), 32'h45);
        // R8 wrap at the top of the address space
        access(1'b0, 1'b0, 8'hFE, 16'h0);
        access(1'b0, 1'b1, 8'hFF, 16'h0);
        // R5: back-to-back misaligned accesses give one pulse each
        access(1'b0, 1'b0, 8'h01, 16'h0);
        access(1'b1, 1'b0, 8'h03, 16'h1234);
        access(1'b0, 1'b0, 8'h02, 16'h0);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            ra = AW'($urandom);
            access(1'($urandom), 1'($urandom), ra, 16'($urandom));
            if ($urandom_range(0, 7) == 0) idle();
        end

        // Final sweep of every word against the reference (R7, R3, R4)
        for (int i = 0; i < NBYTE; i += 2) access(1'b0, 1'b0, AW'(i), 16'h0);

        // R9: reset mid-run clears registered outputs
        access(1'b0, 1'b0, 8'h07, 16'h0);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0; req_addr = 8'h09;
        @(posedge clk);
        #1;
        check(trap_pulse == 1'b0, "R9 trap_pulse in reset", 32'(trap_pulse), 32'd0);
        check(rd_valid == 1'b0, "R9 rd_valid in reset", 32'(rd_valid), 32'd0);
        check(trap_addr == '0, "R9 trap_addr in reset", 32'(trap_addr), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        // R9: memory survives reset
        access(1'b0, 1'b0, 8'h20, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule